// File: doc/BRIEF.md
# Event-Driven Interrupt Counter

This block is an 8-bit interrupt timer for a cartridge-side controller. A prescaler and a main counter advance on one of four external event strobes. The four strobes are a CPU cycle, a rise of PPU address line 12, a PPU read and a CPU-space write. The prescaler can be configured 3 or 8 bits wide. The main counter advances each time the masked prescaler wraps, and an active-high interrupt line is raised when the main counter wraps. The line stays high until software acknowledges it.

Software programs the block through an eight-entry register window. Each write presents a 3-bit offset and an 8-bit data byte for one cycle. Values written to the prescaler and the main counter are XORed with a separately written key byte before they are stored. A single mode byte selects the event source, the prescaler width and the count direction (up, down or stopped).

The event generators and the CPU address decoder sit outside this block.

Top module: `irq_event_counter`

## Requirements
- R1: After reset the mode, key, prescaler, main counter and enable are all zero, and `irq` is low. Events therefore cause no counting and no interrupt.
- R2: Mode bits 7:6 set the direction. 01 counts up and 10 counts down. 00 and 11 hold both the prescaler and the main counter.
- R3: Mode bits 1:0 select the event source: 0 = `ev_cpu_cycle`, 1 = `ev_a12_rise`, 2 = `ev_ppu_read`, 3 = `ev_cpu_write`. Strobes on the unselected inputs have no effect.
- R4: Mode bit 2 set masks the prescaler compare to its low 3 bits, and clear uses all 8 bits. When counting up, the main counter steps when the incremented, masked prescaler is zero. When counting down, it steps when the decremented, masked prescaler is all ones.
- R5: A write to offset 6 stores the key. A write to offset 4 loads the prescaler with data XOR key. A write to offset 5 loads the main counter with data XOR key.
- R6: `irq` is raised when a main-counter step produces 0x00 (counting up) or 0xFF (counting down), provided the enable is set. With the enable clear, a wrap leaves `irq` low.
- R7: A write to offset 0 sets the enable from data bit 0. When that bit is 0, the write also clears `irq`. A write to offset 2 clears the enable and clears `irq`. A write to offset 3 sets the enable and leaves `irq` unchanged.
- R8: Once high, `irq` stays high, through further events and wraps, until it is cleared as R7 describes.
- R9: In source 1, each `ev_a12_rise` strobe produces 8 prescaler events, one per clock, on the 8 edges after the edge that samples the strobe.
- R10: A write to offset 1 stores the mode byte. A write to offset 7 has no effect.
- R11: For sources 0, 2 and 3, a strobe sampled at clock edge k updates the prescaler, the main counter and `irq` at that same edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register offset in the window |
| wr_data | input | 8 | Write data |
| ev_cpu_cycle | input | 1 | CPU cycle event strobe |
| ev_a12_rise | input | 1 | PPU address line 12 rise strobe |
| ev_ppu_read | input | 1 | PPU read event strobe |
| ev_cpu_write | input | 1 | CPU-space write event strobe |
| irq | output | 1 | Interrupt request, active high |

## Verification
Register writes take effect at the edge that samples them. A direct event strobe updates `irq` at that same edge. An address-line-12 strobe finishes its last prescaler step 8 edges later.

The bench drives every input on the falling edge and holds each strobe for exactly one rising edge. It samples `irq` on the next falling edge, which places each check one edge after the direct strobe that should flip it.

For the burst case, the bench samples after the seventh and after the eighth following edge. This confirms that the interrupt arrives neither early nor late.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int CNT_W    = 8;
  localparam int NARROW_W = 3;
  localparam int REG_AW   = 3;

  localparam logic [REG_AW-1:0] OFF_ENABLE  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_MODE    = 3'd1;
  localparam logic [REG_AW-1:0] OFF_DISARM  = 3'd2;
  localparam logic [REG_AW-1:0] OFF_ARM     = 3'd3;
  localparam logic [REG_AW-1:0] OFF_PRE     = 3'd4;
  localparam logic [REG_AW-1:0] OFF_CNT     = 3'd5;
  localparam logic [REG_AW-1:0] OFF_KEY     = 3'd6;

  localparam logic [1:0] SRC_CPU   = 2'd0;
  localparam logic [1:0] SRC_A12   = 2'd1;
  localparam logic [1:0] SRC_READ  = 2'd2;
  localparam logic [1:0] SRC_WRITE = 2'd3;

  typedef enum logic [1:0] {DIR_HOLD, DIR_UP, DIR_DOWN} dir_e;

  // direction field decode
  function automatic dir_e dir_of(input logic [1:0] f);
    case (f)
      2'b01:   return DIR_UP;
      2'b10:   return DIR_DOWN;
      default: return DIR_HOLD;
    endcase
  endfunction

  // compare mask of the prescaler
  function automatic logic [CNT_W-1:0] pre_mask(input logic narrow);
    return narrow ? {CNT_W{1'b1}} >> (CNT_W - NARROW_W) : {CNT_W{1'b1}};
  endfunction

  // one step in the selected direction
  function automatic logic [CNT_W-1:0] step_val(input logic [CNT_W-1:0] v, input dir_e d);
    case (d)
      DIR_UP:   return v + 1'b1;
      DIR_DOWN: return v - 1'b1;
      default:  return v;
    endcase
  endfunction

  // prescaler has reached its carry point after a step
  function automatic logic pre_hit(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] m,
                                   input dir_e d);
    case (d)
      DIR_UP:   return (v & m) == '0;
      DIR_DOWN: return (v & m) == m;
      default:  return 1'b0;
    endcase
  endfunction

  // main counter has wrapped after a step
  function automatic logic main_wrap(input logic [CNT_W-1:0] v, input dir_e d);
    case (d)
      DIR_UP:   return v == '0;
      DIR_DOWN: return v == '1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  mode_q,
  output logic              en_q,
  output logic              irq_clear,
  output logic              pre_load,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  load_val
);

  logic [CNT_W-1:0] key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      key_q  <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        OFF_ENABLE: en_q   <= wr_data[0];
        OFF_MODE:   mode_q <= wr_data;
        OFF_DISARM: en_q   <= 1'b0;
        OFF_ARM:    en_q   <= 1'b1;
        OFF_KEY:    key_q  <= wr_data;
        default:    ;
      endcase
    end
  end

  always_comb begin
    irq_clear = wr_en && ((wr_addr == OFF_ENABLE && !wr_data[0]) || wr_addr == OFF_DISARM);
    pre_load  = wr_en && (wr_addr == OFF_PRE);
    cnt_load  = wr_en && (wr_addr == OFF_CNT);
    load_val  = wr_data ^ key_q;
  end

  // R7
  en_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFF_ARM) |=> en_q);

  // R7
  en_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFF_DISARM) |=> !en_q);

  // R10
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == OFF_MODE) |=> $stable(mode_q));

endmodule

// File: rtl/irqc_src_sel.sv
module irqc_src_sel
  import irqc_pkg::*;
#(
  parameter int BURST_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src,
  input  logic       ev_cpu_cycle,
  input  logic       ev_a12_rise,
  input  logic       ev_ppu_read,
  input  logic       ev_cpu_write,
  output logic       tick
);

  localparam int BW = $clog2(BURST_LEN) + 2;
  localparam logic [BW-1:0] CAP   = {BW{1'b1}};
  localparam logic [BW:0]   LEN_X = BURST_LEN[BW:0];

  logic [BW-1:0] burst_q;
  logic [BW-1:0] burst_base;
  logic [BW:0]   burst_sum;
  logic [BW-1:0] burst_nxt;
  logic          burst_start;
  logic          burst_tick;

  always_comb begin
    burst_start = ev_a12_rise && (src == SRC_A12);
    burst_tick  = burst_q != '0;
    burst_base  = burst_q - {{(BW-1){1'b0}}, burst_tick};
    burst_sum   = {1'b0, burst_base} + LEN_X;
    if (!burst_start)        burst_nxt = burst_base;
    else if (burst_sum[BW])  burst_nxt = CAP;
    else                     burst_nxt = burst_sum[BW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) burst_q <= '0;
    else        burst_q <= burst_nxt;
  end

  always_comb begin
    case (src)
      SRC_CPU:   tick = ev_cpu_cycle;
      SRC_A12:   tick = burst_tick;
      SRC_READ:  tick = ev_ppu_read;
      default:   tick = ev_cpu_write;
    endcase
  end

  // R9
  burst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && burst_q == '0) |=> (burst_q == BURST_LEN[BW-1:0]));

  // R9
  burst_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_start && burst_q != '0) |=> (burst_q == $past(burst_q) - 1'b1));

  // R1
  burst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_start && burst_q == '0) |=> (burst_q == '0));

endmodule

// File: rtl/irqc_counter.sv
module irqc_counter
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  dir_e             dir,
  input  logic             narrow,
  input  logic             pre_load,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  input  logic             irq_clear,
  output logic             irq_q
);

  logic [CNT_W-1:0] pre_q, cnt_q;
  logic [CNT_W-1:0] pre_nxt, cnt_nxt;
  logic             pre_step;
  logic             main_clk;
  logic             raise;

  always_comb begin
    pre_step = tick && (dir != DIR_HOLD);
    pre_nxt  = step_val(pre_q, dir);
    main_clk = pre_step && !pre_load && pre_hit(pre_nxt, pre_mask(narrow), dir);
    cnt_nxt  = step_val(cnt_q, dir);
    raise    = main_clk && !cnt_load && main_wrap(cnt_nxt, dir) && en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (pre_load)      pre_q <= load_val;
      else if (pre_step) pre_q <= pre_nxt;
      if (cnt_load)      cnt_q <= load_val;
      else if (main_clk) cnt_q <= cnt_nxt;
      if (irq_clear)     irq_q <= 1'b0;
      else if (raise)    irq_q <= 1'b1;
    end
  end

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clear) |=> irq_q);

  // R7
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |=> !irq_q);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(en && main_clk));

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_HOLD && !pre_load && !cnt_load) |=> ($stable(pre_q) && $stable(cnt_q)));

  // R4
  main_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_clk && !cnt_load) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/irq_event_counter.sv
module irq_event_counter
  import irqc_pkg::*;
#(
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              ev_cpu_cycle,
  input  logic              ev_a12_rise,
  input  logic              ev_ppu_read,
  input  logic              ev_cpu_write,
  output logic              irq
);

  logic [CNT_W-1:0] mode_q;
  logic             en_q;
  logic             irq_clear;
  logic             pre_load;
  logic             cnt_load;
  logic [CNT_W-1:0] load_val;
  logic             tick;
  dir_e             dir;
  logic             unused_mode_bits;

  assign dir              = dir_of(mode_q[7:6]);
  assign unused_mode_bits = ^mode_q[5:3];

  irqc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mode_q    (mode_q),
    .en_q      (en_q),
    .irq_clear (irq_clear),
    .pre_load  (pre_load),
    .cnt_load  (cnt_load),
    .load_val  (load_val)
  );

  irqc_src_sel #(.BURST_LEN(BURST_LEN)) u_src (
    .clk          (clk),
    .rst_n        (rst_n),
    .src          (mode_q[1:0]),
    .ev_cpu_cycle (ev_cpu_cycle),
    .ev_a12_rise  (ev_a12_rise),
    .ev_ppu_read  (ev_ppu_read),
    .ev_cpu_write (ev_cpu_write),
    .tick         (tick)
  );

  irqc_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .dir       (dir),
    .narrow    (mode_q[2]),
    .pre_load  (pre_load),
    .cnt_load  (cnt_load),
    .load_val  (load_val),
    .en        (en_q),
    .irq_clear (irq_clear),
    .irq_q     (irq)
  );

  // R1
  irq_low_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !en_q) |=> !irq);

endmodule

// File: tb/sim_irq_event_counter.sv
`timescale 1ns/1ps
module sim_irq_event_counter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ev_cpu_cycle = 1'b0;
  logic       ev_a12_rise = 1'b0;
  logic       ev_ppu_read = 1'b0;
  logic       ev_cpu_write = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_event_counter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_cpu_cycle(ev_cpu_cycle), .ev_a12_rise(ev_a12_rise), .ev_ppu_read(ev_ppu_read),
    .ev_cpu_write(ev_cpu_write), .irq(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // which: 0 cpu cycle, 1 a12 rise, 2 ppu read, 3 cpu write
  task automatic ev(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (which)
        0: ev_cpu_cycle = 1'b1;
        1: ev_a12_rise  = 1'b1;
        2: ev_ppu_read  = 1'b1;
        default: ev_cpu_write = 1'b1;
      endcase
      @(negedge clk);
      ev_cpu_cycle = 1'b0; ev_a12_rise = 1'b0; ev_ppu_read = 1'b0; ev_cpu_write = 1'b0;
    end
  endtask

  task automatic setup(input logic [7:0] mode, input logic [7:0] key,
                       input logic [7:0] pre, input logic [7:0] cnt, input bit arm);
    wr(3'd2, 8'h00);
    wr(3'd1, mode);
    wr(3'd6, key);
    wr(3'd4, pre ^ key);
    wr(3'd5, cnt ^ key);
    if (arm) wr(3'd3, 8'h00);
  endtask

  task automatic t_reset;
    chk("R1 reset irq low", irq, 1'b0);
    wr(3'd3, 8'h00);
    ev(0, 3); ev(2, 3); ev(3, 3);
    chk("R1 reset mode stops counting", irq, 1'b0);
  endtask

  task automatic t_stopped;
    setup(8'h00, 8'h00, 8'hFF, 8'hFF, 1);
    ev(0, 4);
    chk("R2 direction 00 holds", irq, 1'b0);
    setup(8'hC0, 8'h00, 8'hFF, 8'hFF, 1);
    ev(0, 4);
    chk("R2 direction 11 holds", irq, 1'b0);
  endtask

  task automatic t_up;
    setup(8'h40, 8'h00, 8'hFE, 8'hFF, 1);
    ev(0, 1);
    chk("R11 up, one event short of wrap", irq, 1'b0);
    ev(0, 1);
    chk("R6 R11 up wrap raises irq same edge", irq, 1'b1);
    ev(0, 5);
    chk("R8 irq held through further events", irq, 1'b1);
    wr(3'd2, 8'h00);
    chk("R7 offset 2 clears irq", irq, 1'b0);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    ev(0, 1);
    chk("R6 wrap with enable clear leaves irq low", irq, 1'b0);
  endtask

  task automatic t_enable;
    setup(8'h40, 8'h00, 8'hFF, 8'hFF, 0);
    wr(3'd0, 8'h01);
    ev(0, 1);
    chk("R7 offset 0 bit0=1 enables", irq, 1'b1);
    wr(3'd0, 8'h01);
    chk("R7 offset 0 bit0=1 keeps pending irq", irq, 1'b1);
    wr(3'd3, 8'h00);
    chk("R7 offset 3 keeps pending irq", irq, 1'b1);
    wr(3'd0, 8'h00);
    chk("R7 offset 0 bit0=0 clears irq", irq, 1'b0);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    ev(0, 1);
    chk("R7 offset 0 bit0=0 disables", irq, 1'b0);
  endtask

  task automatic t_key;
    setup(8'h40, 8'h5A, 8'hFF, 8'hFF, 1);
    ev(0, 1);
    chk("R5 loads XORed with key", irq, 1'b1);
  endtask

  task automatic t_down;
    setup(8'h80, 8'h00, 8'h01, 8'h00, 1);
    ev(0, 1);
    chk("R2 down, prescaler at zero no step", irq, 1'b0);
    ev(0, 1);
    chk("R2 R6 down wrap to FF raises irq", irq, 1'b1);
  endtask

  task automatic t_width;
    setup(8'h40, 8'h00, 8'h07, 8'hFF, 1);
    ev(0, 1);
    chk("R4 8-bit prescaler no carry at 08", irq, 1'b0);
    setup(8'h44, 8'h00, 8'h07, 8'hFF, 1);
    ev(0, 1);
    chk("R4 3-bit prescaler carries at 08", irq, 1'b1);
    setup(8'h44, 8'h00, 8'h00, 8'hFE, 1);
    ev(0, 15);
    chk("R4 3-bit, 15 events one step short", irq, 1'b0);
    ev(0, 1);
    chk("R4 3-bit, 16 events two main steps", irq, 1'b1);
  endtask

  task automatic t_sources;
    setup(8'h42, 8'h00, 8'hFF, 8'hFF, 1);
    ev(0, 1); ev(1, 1); ev(3, 1);
    repeat (12) @(negedge clk);
    chk("R3 source 2 ignores other strobes", irq, 1'b0);
    ev(2, 1);
    chk("R3 source 2 counts ppu reads", irq, 1'b1);
    setup(8'h43, 8'h00, 8'hFF, 8'hFF, 1);
    ev(0, 1); ev(2, 1); ev(1, 1);
    repeat (12) @(negedge clk);
    chk("R3 source 3 ignores other strobes", irq, 1'b0);
    ev(3, 1);
    chk("R3 source 3 counts cpu writes", irq, 1'b1);
  endtask

  task automatic t_a12;
    setup(8'h41, 8'h00, 8'hF8, 8'hFF, 1);
    ev(0, 2); ev(2, 2);
    chk("R3 source 1 ignores cpu cycles", irq, 1'b0);
    ev(1, 1);
    repeat (7) @(negedge clk);
    chk("R9 seven burst ticks not yet wrapped", irq, 1'b0);
    @(negedge clk);
    chk("R9 eighth burst tick wraps", irq, 1'b1);
    setup(8'h45, 8'h00, 8'h00, 8'hFF, 1);
    ev(1, 1);
    repeat (8) @(negedge clk);
    chk("R9 3-bit burst carries once", irq, 1'b1);
  endtask

  task automatic t_off7;
    setup(8'h40, 8'h00, 8'hFE, 8'hFF, 1);
    wr(3'd7, 8'hFF); wr(3'd7, 8'h00);
    ev(0, 1);
    chk("R10 offset 7 no effect, not yet wrapped", irq, 1'b0);
    ev(0, 1);
    chk("R10 offset 7 no effect, wrap on schedule", irq, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_up();
    t_enable();
    t_key();
    t_down();
    t_width();
    t_sources();
    t_a12();
    t_off7();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule